// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block turns a simple clocked request port into the pin sequences of an external byte-wide asynchronous static RAM with a 21-bit address. A request is accepted when `req_valid` and `req_ready` are both high. A write is then played out as select, a strobe of write enable and a hold phase. A read is played out as select with output enable low, and the returned byte is captured at the end of the access. The memory is selected only while its active-low enable is low and its active-high enable is high. Between operations both enables are inactive, so the part sits in standby with its data pins floating.

All pin timing is derived from one clock-period parameter and a set of nanosecond limits. Each phase lasts the ceiling of its limit divided by the clock period, and at least one cycle. The two speed grades of the memory are reached by changing only these parameters. The data bus is split into an output value, an output enable and an input value. Bus drive is confined to the write strobe and its hold cycle, and it starts only after output enable has been high for a full cycle. Every operation returns to idle before the next one starts, which guarantees a released-bus cycle before any read.

States and transitions: `ST_IDLE` (deselected, ready) goes to `ST_WSETUP` on an accepted write and to `ST_RACCESS` on an accepted read. `ST_WSETUP` (selected, strobe high, bus released) always goes to `ST_WPULSE`. `ST_WPULSE` (write enable low, bus driven) goes to `ST_WHOLD` when its count ends. `ST_WHOLD` (write enable high, bus still driven) goes to `ST_IDLE` when its count ends. `ST_RACCESS` (output enable low) captures data and goes to `ST_IDLE` when its count ends.

Top module: `asram_ctrl`

## Requirements
- R1: After reset the active-low enable, write enable and output enable are 1, the active-high enable is 0, the bus output enable is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Whenever `req_ready` is 1 the memory is deselected (active-low enable 1, active-high enable 0); it is selected only while an operation is in progress.
- R3: Write enable is low only while the memory is selected and output enable is high, the bus is driven for every cycle write enable is low, and the byte driven is the one stored at the requested address.
- R4: Write enable stays low for exactly max(ceil(T_PWE/CLK), ceil(T_SD/CLK), ceil(T_AW/CLK)-1, 1) cycles, which is 4 with the default parameters.
- R5: A write occupies 1 + pulse + max(1, ceil(T_WC/CLK) - pulse - 1) cycles from acceptance to the return of `req_ready`, which is 6 with the default parameters.
- R6: A read holds output enable low, with write enable high and the bus released, for exactly max(ceil(T_RC/CLK), ceil(T_AA/CLK), ceil(T_DOE/CLK), 1) cycles, which is 6 with the default parameters.
- R7: The byte on the data input at the edge that ends the read is presented on `rsp_rdata` together with a `rsp_valid` pulse exactly one cycle long, in the cycle `req_ready` returns.
- R8: `req_ready` is low from the edge that accepts a request until the operation completes.
- R9: The bus is driven only when output enable is high and was also high in the previous cycle.
- R10: In the cycle after the bus was driven, output enable is still high, so a read never begins straight after a write.
- R11: The memory address stays stable for as long as the memory remains selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Read byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| mem_ce_n | output | 1 | Active-low memory enable |
| mem_ce | output | 1 | Active-high memory enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 21 | Memory address |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
The assertions take for granted that `rst_n` is low from time zero until after the first clock edges. They also assume that `req_valid`, `req_write`, `req_addr` and `req_wdata` change only away from the rising edge. The stimulus drives every input just after a falling edge and releases reset on a falling edge. It models the memory so that the data input shows the stored byte only while the memory is selected, in read mode, with output enable low. Outside that window it shows a filler byte.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACCESS
    } asram_state_t;

    // cycles needed to cover t_ns at a clock period of clk_ns, never below one
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_capture.sv
`timescale 1ns/1ps
module asram_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            dvalid <= cap_en;
            if (cap_en) begin
                dout <= din;
            end
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 10,
    parameter int T_WC_NS  = 55,
    parameter int T_PWE_NS = 40,
    parameter int T_SD_NS  = 25,
    parameter int T_AW_NS  = 40,
    parameter int T_RC_NS  = 55,
    parameter int T_AA_NS  = 55,
    parameter int T_DOE_NS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // phase lengths in clock cycles
    localparam int WP_CYC   = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                                   ns_to_cyc(T_AW_NS, CLK_NS) - 1);
    localparam int WC_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int HOLD_CYC = imax(1, WC_CYC - WP_CYC - 1);
    localparam int RD_CYC   = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                   ns_to_cyc(T_DOE_NS, CLK_NS));
    localparam int MAX_CYC  = imax(imax(WP_CYC, HOLD_CYC), RD_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    asram_state_t     st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              cap_en;
    logic              accept;

    assign accept = req_valid && (st_q == ST_IDLE);

    asram_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // transitions
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        st_d = ST_WSETUP;
                    end else begin
                        st_d     = ST_RACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_WSETUP: begin
                st_d     = ST_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WP_CYC - 1);
            end
            ST_WPULSE: begin
                if (tmr_zero) begin
                    st_d     = ST_WHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HOLD_CYC - 1);
                end
            end
            ST_WHOLD: begin
                if (tmr_zero) st_d = ST_IDLE;
            end
            ST_RACCESS: begin
                if (tmr_zero) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // pin levels decoded from the state register
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_ce    = 1'b0;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_WSETUP: begin
                mem_ce_n = 1'b0;
                mem_ce   = 1'b1;
            end
            ST_WPULSE: begin
                mem_ce_n  = 1'b0;
                mem_ce    = 1'b1;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WHOLD: begin
                mem_ce_n  = 1'b0;
                mem_ce    = 1'b1;
                mem_dq_oe = 1'b1;
            end
            ST_RACCESS: begin
                mem_ce_n = 1'b0;
                mem_ce   = 1'b1;
                mem_oe_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign cap_en     = (st_q == ST_RACCESS) && tmr_zero;
    assign req_ready  = (st_q == ST_IDLE);
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    asram_capture #(.DATA_W(DATA_W)) cap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (mem_dq_in),
        .dout   (rsp_rdata),
        .dvalid (rsp_valid)
    );
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe
);
    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_ce)); // R2
    AST_WE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_ce && mem_oe_n)); // R3
    AST_WE_BUS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe); // R3
    AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe && !mem_ce_n && mem_ce)); // R6
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7
    AST_VALID_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready); // R7
    AST_DRIVE_AFTER_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n))); // R9
    AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_dq_oe) |-> mem_oe_n); // R10
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R11
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 21;
    localparam int DW = 8;
    localparam int T_WC = 55, T_PWE = 40, T_SD = 25, T_AW = 40;
    localparam int T_RC = 55, T_AA = 55, T_DOE = 25;

    function automatic int cdiv(input int t);
        int c;
        c = (t + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_WP  = mx(mx(cdiv(T_PWE), cdiv(T_SD)), cdiv(T_AW) - 1);
    localparam int EXP_WR  = 1 + EXP_WP + mx(1, cdiv(T_WC) - EXP_WP - 1);
    localparam int EXP_RD  = mx(mx(cdiv(T_RC), cdiv(T_AA)), cdiv(T_DOE));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hA5;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_PERIOD),
                 .T_WC_NS(T_WC), .T_PWE_NS(T_PWE), .T_SD_NS(T_SD), .T_AW_NS(T_AW),
                 .T_RC_NS(T_RC), .T_AA_NS(T_AA), .T_DOE_NS(T_DOE)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid), .mem_ce_n(mem_ce_n),
        .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // memory model and pin monitors, evaluated at falling edges
    logic [DW-1:0] mem_model [int unsigned];
    bit win = 0;
    logic [AW-1:0] win_addr;
    logic [DW-1:0] win_data;
    int we_run = 0, last_we_run = 0, oe_run = 0, last_oe_run = 0;
    int drv_viol = 0, rd_viol = 0, ta_viol = 0, sel_viol = 0, addr_viol = 0, drv9_viol = 0;
    bit prev_dq_oe = 0, prev_oe_n = 1, prev_sel = 0;
    logic [AW-1:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit sel;
            sel = !mem_ce_n && mem_ce;
            if (sel && !mem_we_n) begin
                win = 1; win_addr = mem_addr; win_data = mem_dq_out;
            end else if (win) begin
                mem_model[int'(win_addr)] = win_data;
                win = 0;
            end
            if (!mem_we_n) we_run++;
            else if (we_run != 0) begin last_we_run = we_run; we_run = 0; end
            if (!mem_oe_n) oe_run++;
            else if (oe_run != 0) begin last_oe_run = oe_run; oe_run = 0; end
            if (!mem_we_n && !mem_dq_oe) drv_viol++;
            if (!mem_oe_n && (mem_dq_oe || !mem_we_n)) rd_viol++;
            if (prev_dq_oe && !mem_oe_n) ta_viol++;
            if (req_ready && sel) sel_viol++;
            if (mem_dq_oe && !(mem_oe_n && prev_oe_n)) drv9_viol++;
            if (sel && prev_sel && mem_addr != prev_addr) addr_viol++;
            if (sel && !mem_oe_n && mem_we_n)
                mem_dq_in = mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)] : 8'h00;
            else
                mem_dq_in = 8'hA5;
            prev_dq_oe = mem_dq_oe; prev_oe_n = mem_oe_n;
            prev_sel = sel; prev_addr = mem_addr;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // issue one request just after a falling edge; returns just after the
    // falling edge where ready is back, with cyc = cycles from acceptance
    task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int cyc, output int busy_ready);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; req_write = 0; req_wdata = 8'h3C;
        busy_ready = 0;
        cyc = 1;
        if (req_ready) busy_ready++;
        while (!req_ready && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        #1;
        cyc = cyc - 1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(mem_ce_n == 1 && mem_ce == 0, "R1", "enables in reset", {mem_ce_n, mem_ce}, 2);
        check(mem_we_n == 1 && mem_oe_n == 1, "R1", "strobes in reset", {mem_we_n, mem_oe_n}, 3);
        check(mem_dq_oe == 0, "R1", "bus drive in reset", mem_dq_oe, 0);
        check(req_ready == 1 && rsp_valid == 0, "R1", "ready/valid in reset", {req_ready, rsp_valid}, 2);
        rst_n = 1;
        @(negedge clk); @(negedge clk);
        #1;
        check(mem_ce_n == 1 && mem_ce == 0 && mem_dq_oe == 0, "R1", "idle after reset",
              {mem_ce_n, mem_ce, mem_dq_oe}, 4);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int cyc, br;
        run_op(1, a, d, cyc, br);
        check(last_we_run == EXP_WP, "R4", "write strobe cycles", last_we_run, EXP_WP);
        check(cyc == EXP_WR, "R5", "write length", cyc, EXP_WR);
        check(br == 0, "R8", "ready during write", br, 0);
        check(mem_model.exists(int'(a)) && mem_model[int'(a)] == d, "R3", "stored byte",
              mem_model.exists(int'(a)) ? int'(mem_model[int'(a)]) : -1, int'(d));
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp_d);
        int cyc, br;
        run_op(0, a, 8'h00, cyc, br);
        check(cyc == EXP_RD, "R6", "read length", cyc, EXP_RD);
        check(last_oe_run == EXP_RD, "R6", "output enable low cycles", last_oe_run, EXP_RD);
        check(br == 0, "R8", "ready during read", br, 0);
        check(rsp_valid == 1, "R7", "valid with ready", rsp_valid, 1);
        check(rsp_rdata == exp_d, "R7", "read byte", rsp_rdata, exp_d);
    endtask

    task automatic t_valid_pulse();
        @(negedge clk); #1;
        check(rsp_valid == 0, "R7", "valid one cycle", rsp_valid, 0);
    endtask

    // write followed at once by a read of the same word, then read then write
    task automatic t_back_to_back();
        int cyc, br;
        run_op(1, 21'h00_0123, 8'h5A, cyc, br);
        run_op(0, 21'h00_0123, 8'h00, cyc, br);
        check(rsp_valid == 1 && rsp_rdata == 8'h5A, "R7", "read right after write",
              rsp_rdata, 8'h5A);
        run_op(1, 21'h00_0124, 8'hC3, cyc, br);
        check(cyc == EXP_WR, "R5", "write right after read", cyc, EXP_WR);
        run_op(0, 21'h00_0124, 8'h00, cyc, br);
        check(rsp_rdata == 8'hC3, "R7", "second tight read", rsp_rdata, 8'hC3);
    endtask

    task automatic t_monitors();
        check(drv_viol == 0, "R3", "bus undriven under strobe", drv_viol, 0);
        check(rd_viol == 0, "R6", "read with bus/strobe conflict", rd_viol, 0);
        check(sel_viol == 0, "R2", "selected while ready", sel_viol, 0);
        check(drv9_viol == 0, "R9", "drive without settled OE", drv9_viol, 0);
        check(ta_viol == 0, "R10", "read right after drive", ta_viol, 0);
        check(addr_viol == 0, "R11", "address moved while selected", addr_viol, 0);
    endtask

    initial begin
        t_reset();
        t_write(21'h00_0000, 8'h11);
        t_write(21'h1F_FFFF, 8'hFE);
        t_write(21'h0A_5A5A, 8'h00);
        t_write(21'h15_A5A5, 8'hFF);
        t_read(21'h00_0000, 8'h11);
        t_valid_pulse();
        t_read(21'h1F_FFFF, 8'hFE);
        t_read(21'h0A_5A5A, 8'h00);
        t_read(21'h15_A5A5, 8'hFF);
        t_write(21'h00_0000, 8'h96);
        t_read(21'h00_0000, 8'h96);
        t_back_to_back();
        t_valid_pulse();
        t_monitors();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule